// File: doc/BRIEF.md
# Time Base with Interval Tap

This block keeps a 64-bit free-running count, held as an upper and a lower 32-bit half, and raises a fixed-interval event from one chosen bit of that count. The count only moves while the time-base enable input is high. A source-select input picks the step source. With select low, the count steps on every core clock. With select high, it steps once per rising edge of an external tick, which is first brought into the core clock domain.

Software can replace either half of the count at any time. It sets a 6-bit tap index from a 4-bit extension field and a 2-bit period field. When the tapped bit goes from 0 to 1, a sticky status flag is set. Software clears the flag by writing a 1 to it. An interrupt request is raised when the flag, a local interrupt enable and an external interrupt-enable input are all high.

Top module: `tbase_tap_top`

## Requirements
- R1: A synchronous active-high reset clears both count halves, the tap index, the local interrupt enable and the status flag, and so holds `fi_irq` low.
- R2: When the lower half steps from 0xFFFF_FFFF, it becomes 0 and the upper half steps by one. A step from the all-ones 64-bit value gives zero and sets no flag.
- R3: While `tb_en` is 0 the count keeps its value, whatever the source select and the external tick do.
- R4: With `tb_en`=1 and `clk_sel`=0, the 64-bit count grows by exactly one on each core clock edge.
- R5: With `tb_en`=1 and `clk_sel`=1, the count grows by one for each rising edge of `ext_tick`. Each such edge passes a two-flop synchronizer, so the step lands on the third clock edge after the tick is first sampled high. A tick that is held high gives only one step.
- R6: `wr_hi` or `wr_lo` loads `wr_data` into that half on the next edge. A cycle that carries any half write performs no hardware step.
- R7: A write on `ctl_wr` sets the tap index to {`ctl_ext`,`ctl_per`} and the local enable to `ctl_ie`. Index 0 taps bit 63 of the count (MSB of the upper half), and index 63 taps bit 0 (LSB of the lower half).
- R8: A 0-to-1 change of the tapped bit between two consecutive clock edges sets `fi_status` on the following edge. The flag then stays set, even after the bit falls.
- R9: A `sts_wr` with `sts_wdata`=1 clears `fi_status`, and a `sts_wr` with `sts_wdata`=0 leaves it alone. When a new event and a clear arrive in the same cycle, the event wins.
- R10: In the cycle after the tap index changes, no event is detected, even if the newly tapped bit is 1 and the old one was 0.
- R11: `fi_irq` is high exactly when `fi_status`, `int_en` and `irq_en_in` are all 1. It is combinational in `irq_en_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| tb_en | input | 1 | Time-base enable |
| clk_sel | input | 1 | Step source: 0 core clock, 1 external tick |
| ext_tick | input | 1 | Asynchronous external timer tick |
| wr_hi | input | 1 | Load upper half from wr_data |
| wr_lo | input | 1 | Load lower half from wr_data |
| wr_data | input | 32 | Write data for a half |
| ctl_wr | input | 1 | Load tap fields and local enable |
| ctl_ext | input | 4 | Tap index extension (index bits 5:2) |
| ctl_per | input | 2 | Tap index period (index bits 1:0) |
| ctl_ie | input | 1 | Local interrupt enable value |
| sts_wr | input | 1 | Status write strobe |
| sts_wdata | input | 1 | Status write data, 1 clears |
| irq_en_in | input | 1 | External interrupt-enable gate |
| count_hi | output | 32 | Upper half of the count |
| count_lo | output | 32 | Lower half of the count |
| tap_index | output | 6 | Current tap index |
| int_en | output | 1 | Local interrupt enable |
| fi_status | output | 1 | Sticky fixed-interval status |
| fi_irq | output | 1 | Interrupt request |

## Verification
The assertions run on every cycle. They check that the count holds while disabled, steps by one in core-clock mode, carries correctly out of the lower half, takes a half write in place of the step, and keeps the status flag sticky unless a 1 is written. They also check that the request never rises without the flag, the local enable and the external gate. Some behaviour only the bench scenarios can show, because it depends on sequences of inputs. These are the three-edge delay of the synchronized tick and its single step per held level, the mapping of index 0 and index 63 onto the count, the event winning over a clear in the same cycle, and the missing event just after the tap moves. The bench compares all of these against a behavioural model on every clock.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

    localparam int HALF_W      = 32;
    localparam int CNT_W       = 2 * HALF_W;
    localparam int IDX_W       = $clog2(CNT_W);
    localparam int PER_W       = 2;
    localparam int EXT_W       = IDX_W - PER_W;
    localparam int SYNC_STAGES = 2;

    typedef enum logic {
        SRC_CORE = 1'b0,
        SRC_TICK = 1'b1
    } tb_src_e;

    typedef struct packed {
        logic [EXT_W-1:0] ext;
        logic [PER_W-1:0] per;
    } tap_sel_t;

    typedef struct packed {
        tap_sel_t sel;
        logic     ie;
    } tap_cfg_t;

    function automatic logic step_allowed(input logic en, input tb_src_e src,
                                          input logic tick_rise);
        logic r;
        r = 1'b0;
        if (en) begin
            r = (src == SRC_TICK) ? tick_rise : 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/tbase_sync_edge.sv
module tbase_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    localparam int LAST = STAGES;

    logic [LAST:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain[0] <= din;
        end
    end

    for (genvar g = 1; g <= LAST; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                chain[g] <= 1'b0;
            end else begin
                chain[g] <= chain[g-1];
            end
        end
    end

    // chain[LAST-1] is the synchronized level, chain[LAST] its previous value
    assign rise = chain[LAST-1] & ~chain[LAST];

endmodule

// File: rtl/tbase_counter.sv
module tbase_counter #(
    parameter int HALF_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [HALF_W-1:0] wr_data,
    output logic [HALF_W-1:0] hi_q,
    output logic [HALF_W-1:0] lo_q
);
    logic [HALF_W:0] lo_inc;
    logic            carry;
    logic            adv;

    assign lo_inc = {1'b0, lo_q} + {{HALF_W{1'b0}}, 1'b1};
    assign carry  = lo_inc[HALF_W];
    // any software write to either half cancels the hardware step
    assign adv    = step & ~(wr_hi | wr_lo);

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
        end else if (wr_lo) begin
            lo_q <= wr_data;
        end else if (adv) begin
            lo_q <= lo_inc[HALF_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= '0;
        end else if (wr_hi) begin
            hi_q <= wr_data;
        end else if (adv && carry) begin
            hi_q <= hi_q + {{(HALF_W-1){1'b0}}, 1'b1};
        end
    end

endmodule

// File: rtl/tbase_tap_event.sv
module tbase_tap_event #(
    parameter int CNT_W = 64,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] count,
    input  logic [IDX_W-1:0] idx,
    input  logic             clr,
    output logic             status
);
    logic [CNT_W-1:0] shifted;
    logic             tapped;
    logic             tapped_q;
    logic [IDX_W-1:0] idx_q;
    logic             evt;

    // index 0 lands on the MSB: shift left by idx and take the top bit
    assign shifted = count << idx;
    assign tapped  = shifted[CNT_W-1];
    assign evt     = tapped & ~tapped_q & (idx == idx_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            tapped_q <= 1'b0;
            idx_q    <= '0;
        end else begin
            tapped_q <= tapped;
            idx_q    <= idx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= 1'b0;
        end else if (evt) begin
            status <= 1'b1;
        end else if (clr) begin
            status <= 1'b0;
        end
    end

endmodule

// File: rtl/tbase_tap_top.sv
module tbase_tap_top
    import tbase_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tb_en,
    input  logic              clk_sel,
    input  logic              ext_tick,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [HALF_W-1:0] wr_data,
    input  logic              ctl_wr,
    input  logic [EXT_W-1:0]  ctl_ext,
    input  logic [PER_W-1:0]  ctl_per,
    input  logic              ctl_ie,
    input  logic              sts_wr,
    input  logic              sts_wdata,
    input  logic              irq_en_in,
    output logic [HALF_W-1:0] count_hi,
    output logic [HALF_W-1:0] count_lo,
    output logic [IDX_W-1:0]  tap_index,
    output logic              int_en,
    output logic              fi_status,
    output logic              fi_irq
);
    tap_cfg_t cfg_q;
    logic     tick_rise;
    logic     step;
    tb_src_e  src;

    tbase_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (ext_tick),
        .rise (tick_rise)
    );

    assign src  = tb_src_e'(clk_sel);
    assign step = step_allowed(tb_en, src, tick_rise);

    tbase_counter #(.HALF_W(HALF_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .step    (step),
        .wr_hi   (wr_hi),
        .wr_lo   (wr_lo),
        .wr_data (wr_data),
        .hi_q    (count_hi),
        .lo_q    (count_lo)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (ctl_wr) begin
            cfg_q.sel.ext <= ctl_ext;
            cfg_q.sel.per <= ctl_per;
            cfg_q.ie      <= ctl_ie;
        end
    end

    assign tap_index = cfg_q.sel;
    assign int_en    = cfg_q.ie;

    tbase_tap_event #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_evt (
        .clk    (clk),
        .rst    (rst),
        .count  ({count_hi, count_lo}),
        .idx    (tap_index),
        .clr    (sts_wr & sts_wdata),
        .status (fi_status)
    );

    assign fi_irq = fi_status & int_en & irq_en_in;

endmodule

// File: rtl/tbase_tap_chk.sv
module tbase_tap_chk
    import tbase_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tb_en,
    input logic              clk_sel,
    input logic              wr_hi,
    input logic              wr_lo,
    input logic [HALF_W-1:0] wr_data,
    input logic              sts_wr,
    input logic              sts_wdata,
    input logic              irq_en_in,
    input logic [HALF_W-1:0] count_hi,
    input logic [HALF_W-1:0] count_lo,
    input logic              int_en,
    input logic              fi_status,
    input logic              fi_irq
);
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!tb_en && !wr_hi && !wr_lo) |=> $stable({count_hi, count_lo}));

    p_core_step_r4: assert property (@(posedge clk) disable iff (rst)
        (tb_en && !clk_sel && !wr_hi && !wr_lo)
        |=> {count_hi, count_lo} == $past({count_hi, count_lo}) + 64'd1);

    p_carry_r2: assert property (@(posedge clk) disable iff (rst)
        (!wr_hi && !wr_lo && count_lo == '1)
        |=> (count_lo == '1 && count_hi == $past(count_hi)) ||
            (count_lo == '0 && count_hi == $past(count_hi) + 32'd1));

    p_wr_lo_r6: assert property (@(posedge clk) disable iff (rst)
        wr_lo |=> count_lo == $past(wr_data));

    p_wr_hi_r6: assert property (@(posedge clk) disable iff (rst)
        wr_hi |=> count_hi == $past(wr_data));

    p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (fi_status && !(sts_wr && sts_wdata)) |=> fi_status);

    p_irq_src_r11: assert property (@(posedge clk) disable iff (rst)
        fi_irq |-> (fi_status && int_en));

    p_irq_gate_r11: assert property (@(posedge clk) disable iff (rst)
        !irq_en_in |-> !fi_irq);

endmodule

bind tbase_tap_top tbase_tap_chk u_chk (.*);

// File: tb/sim_tbase_tap_top.sv
module sim_tbase_tap_top;
    localparam int CLK_PERIOD = 10;
    localparam int SAMPLE_DLY = 4;
    localparam int WDOG_LIMIT = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tb_en = 0, clk_sel = 0, ext_tick = 0;
    logic        wr_hi = 0, wr_lo = 0;
    logic [31:0] wr_data = '0;
    logic        ctl_wr = 0, ctl_ie = 0;
    logic [3:0]  ctl_ext = '0;
    logic [1:0]  ctl_per = '0;
    logic        sts_wr = 0, sts_wdata = 0, irq_en_in = 0;
    logic [31:0] count_hi, count_lo;
    logic [5:0]  tap_index;
    logic        int_en, fi_status, fi_irq;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    string cur_req = "R1";

    // behavioural reference state
    logic [63:0] m_cnt;
    logic        m_s1, m_s2, m_s3, m_prev, m_sts, m_ie;
    int          m_idx, m_last;

    tbase_tap_top u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin : model
        logic [63:0] n;
        logic rise, stp, bitv, edg;
        if (rst) begin
            m_cnt = '0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
            m_prev = 0; m_sts = 0; m_ie = 0; m_idx = 0; m_last = 0;
        end else begin
            rise = m_s2 && !m_s3;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_tick;
            stp  = tb_en && (clk_sel ? rise : 1'b1) && !wr_hi && !wr_lo;
            bitv = m_cnt[63 - m_idx];
            edg  = bitv && !m_prev && (m_idx == m_last);
            m_prev = bitv;
            m_last = m_idx;
            if (edg) m_sts = 1'b1;
            else if (sts_wr && sts_wdata) m_sts = 1'b0;
            n = m_cnt;
            if (stp) n = n + 64'd1;
            if (wr_hi) n[63:32] = wr_data;
            if (wr_lo) n[31:0] = wr_data;
            m_cnt = n;
            if (ctl_wr) begin
                m_idx = {ctl_ext, ctl_per};
                m_ie  = ctl_ie;
            end
        end
    end

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_model();
        logic exp_irq;
        exp_irq = m_sts && m_ie && irq_en_in;
        chk({count_hi, count_lo} == m_cnt, cur_req, "count", {count_hi, count_lo}, m_cnt);
        chk(tap_index == 6'(m_idx) && int_en == m_ie, cur_req, "cfg",
            {57'd0, int_en, tap_index}, {57'd0, m_ie, 6'(m_idx)});
        chk(fi_status == m_sts, cur_req, "status", 64'(fi_status), 64'(m_sts));
        chk(fi_irq == exp_irq, cur_req, "irq", 64'(fi_irq), 64'(exp_irq));
    endtask

    task automatic cyc(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #SAMPLE_DLY;
            compare_model();
        end
    endtask

    task automatic set_tap(input logic [5:0] idx, input logic ie);
        ctl_wr = 1; ctl_ext = idx[5:2]; ctl_per = idx[1:0]; ctl_ie = ie;
        cyc();
        ctl_wr = 0;
    endtask

    task automatic clear_sts(input logic d);
        sts_wr = 1; sts_wdata = d;
        cyc();
        sts_wr = 0; sts_wdata = 0;
    endtask

    task automatic write_halves(input logic h, input logic l, input logic [31:0] d);
        wr_hi = h; wr_lo = l; wr_data = d;
        cyc();
        wr_hi = 0; wr_lo = 0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WDOG_LIMIT) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] c0;
        cyc(3);
        rst = 0;
        cyc();
        // R1: reset state
        chk({count_hi, count_lo} == 0 && tap_index == 0 && !int_en && !fi_status && !fi_irq,
            "R1", "reset state", {count_hi, count_lo}, 64'd0);

        // R4: core-clock stepping
        cur_req = "R4";
        tb_en = 1;
        cyc(10);
        chk({count_hi, count_lo} == 64'd10, "R4", "ten steps", {count_hi, count_lo}, 64'd10);

        // R3: disabled holds
        cur_req = "R3";
        tb_en = 0;
        cyc(5);
        chk({count_hi, count_lo} == 64'd10, "R3", "held", {count_hi, count_lo}, 64'd10);

        // R6 + R2: write wins over step, then carry
        cur_req = "R6";
        tb_en = 1;
        write_halves(0, 1, 32'hFFFF_FFFE);
        chk({count_hi, count_lo} == 64'h0000_0000_FFFF_FFFE, "R6", "write cancels step",
            {count_hi, count_lo}, 64'h0000_0000_FFFF_FFFE);
        cur_req = "R2";
        cyc(2);
        chk({count_hi, count_lo} == 64'h0000_0001_0000_0000, "R2", "carry",
            {count_hi, count_lo}, 64'h0000_0001_0000_0000);

        // R7 index 0 = MSB; R2 full wrap gives no event
        tb_en = 0;
        cur_req = "R7";
        write_halves(1, 1, 32'hFFFF_FFFF);
        cyc(2);
        chk(fi_status == 1'b1, "R7", "index 0 taps MSB", 64'(fi_status), 64'd1);
        clear_sts(1);
        cur_req = "R2";
        tb_en = 1;
        cyc();
        tb_en = 0;
        chk({count_hi, count_lo} == 64'd0, "R2", "wrap to zero", {count_hi, count_lo}, 64'd0);
        cyc(3);
        chk(fi_status == 1'b0, "R2", "wrap no event", 64'(fi_status), 64'd0);

        // R7 index 63 = LSB; R8 sticky
        cur_req = "R7";
        set_tap(6'd63, 1'b1);
        cyc(2);
        chk(tap_index == 6'd63, "R7", "index from fields", 64'(tap_index), 64'd63);
        write_halves(0, 1, 32'd1);
        cyc();
        chk(fi_status == 1'b1, "R7", "index 63 taps LSB", 64'(fi_status), 64'd1);
        cur_req = "R8";
        write_halves(0, 1, 32'd0);
        cyc(3);
        chk(fi_status == 1'b1, "R8", "sticky after fall", 64'(fi_status), 64'd1);

        // R11 gating
        cur_req = "R11";
        irq_en_in = 1;
        cyc();
        chk(fi_irq == 1'b1, "R11", "irq all high", 64'(fi_irq), 64'd1);
        irq_en_in = 0;
        #1;
        chk(fi_irq == 1'b0, "R11", "external gate low", 64'(fi_irq), 64'd0);
        irq_en_in = 1;
        set_tap(6'd63, 1'b0);
        chk(fi_irq == 1'b0, "R11", "local enable low", 64'(fi_irq), 64'd0);
        set_tap(6'd63, 1'b1);

        // R9 write-0 no effect, write-1 clears, set beats clear
        cur_req = "R9";
        clear_sts(0);
        chk(fi_status == 1'b1, "R9", "write 0 ignored", 64'(fi_status), 64'd1);
        clear_sts(1);
        chk(fi_status == 1'b0, "R9", "write 1 clears", 64'(fi_status), 64'd0);
        tb_en = 1;
        sts_wr = 1; sts_wdata = 1;
        cyc(6);
        sts_wr = 0; sts_wdata = 0;
        tb_en = 0;
        cyc(3);

        // R10 index change produces no event
        cur_req = "R10";
        write_halves(0, 1, 32'd2);
        write_halves(1, 0, 32'h4000_0000);
        cyc(2);
        clear_sts(1);
        cyc(2);
        set_tap(6'd1, 1'b1);
        cyc(3);
        chk(fi_status == 1'b0, "R10", "no edge on index change", 64'(fi_status), 64'd0);

        // R5 external tick
        cur_req = "R5";
        clk_sel = 1; tb_en = 1;
        cyc(4);
        c0 = {count_hi, count_lo};
        ext_tick = 1;
        cyc(2);
        chk({count_hi, count_lo} == c0, "R5", "sync delay", {count_hi, count_lo}, c0);
        cyc();
        chk({count_hi, count_lo} == c0 + 1, "R5", "step on third edge",
            {count_hi, count_lo}, c0 + 1);
        cyc(8);
        chk({count_hi, count_lo} == c0 + 1, "R5", "held tick one step",
            {count_hi, count_lo}, c0 + 1);
        for (int k = 0; k < 8; k++) begin
            ext_tick = ~ext_tick;
            cyc(2);
        end
        for (int k = 0; k < 6; k++) begin
            ext_tick = ~ext_tick;
            cyc(1);
        end
        ext_tick = 0;
        cyc(4);

        // R3 ticks ignored while disabled
        cur_req = "R3";
        tb_en = 0;
        c0 = {count_hi, count_lo};
        for (int k = 0; k < 6; k++) begin
            ext_tick = ~ext_tick;
            cyc(3);
        end
        chk({count_hi, count_lo} == c0, "R3", "ticks while disabled",
            {count_hi, count_lo}, c0);

        // R8 periodic events on a lower tap with core clock
        cur_req = "R8";
        clk_sel = 0; tb_en = 1;
        set_tap(6'd61, 1'b1);
        for (int k = 0; k < 5; k++) begin
            cyc(5);
            clear_sts(1);
        end
        tb_en = 0;
        cyc(2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule